// File: doc/BRIEF.md
# Multiplexed LCD row scan controller

This block sequences a 40-row by 101-column dot-matrix display at a 1:40 multiplex ratio. One frame lasts a fixed 3072 clock cycles. The frame is cut into 40 row slots. 3072 is not a multiple of 40, so 32 slots are one clock longer than the other 8. An accumulator spreads the long slots evenly over the frame.

During each slot the block reads the bank that holds the next row from a banked display memory. It picks one bit per column, applies the selected display mode and latches the result at the slot boundary. The one-hot row select and the 101 column bits therefore change in the same cycle.

A polarity flag toggles at the start of every frame, so that the downstream analog drivers can alternate their drive levels. A power-down input forces every output to the idle level and freezes the scan in place. Display memory and scan position are kept, and the scan resumes where it stopped.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: One frame, counted in clocks where power-down is low, lasts exactly 3072 cycles, from the first cycle of row 0 to the next first cycle of row 0.
- R2: The slot of row r lasts 76 + (floor((r+1)*32/40) - floor(r*32/40)) clocks. This gives 32 slots of 77 clocks and 8 slots of 76 clocks.
- R3: row_sel_o has exactly one bit set while the scan runs, with bit r set for row r. Rows advance 0, 1, ... 39 and then wrap to 0.
- R4: In normal mode, column c of row r is bit (r mod 8) of byte c in bank r/8. The block puts the bank number on rd_bank_o, and byte c arrives on rd_data_i[8c+7:8c]. Bit 0 of a byte is the top line of its bank.
- R5: disp_mode_i encodes the display mode: 2'b00 blank (all columns 0), 2'b01 all on (all columns 1), 2'b10 normal (memory data), 2'b11 inverse (memory data inverted).
- R6: Column data and mode are sampled on the clock edge that starts a slot and are held for the whole slot. A change of memory contents or mode in the middle of a slot shows only from the next slot onward.
- R7: pol_o is 0 throughout the first frame after reset, keeps its value within a frame, and inverts each time the scan wraps from row 39 to row 0.
- R8: While pd_i is 1, row_sel_o, col_o and pol_o are all 0 and the scan position and slot count are frozen. When pd_i returns to 0, the same row comes back with the same data and finishes its remaining slot time.
- R9: While rst_ni is low, all outputs are 0. After rst_ni rises, the outputs stay 0 across the first rising clock edge, and row 0 of frame 0 appears after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset, release synchronized over two edges |
| pd_i | input | 1 | Power-down: idle outputs, scan frozen |
| disp_mode_i | input | 2 | Display mode {enable, data/invert} |
| rd_bank_o | output | 3 | Bank index of the row being fetched |
| rd_data_i | input | 808 | All 101 bytes of the addressed bank, byte c at bits 8c+7:8c |
| row_sel_o | output | 40 | One-hot row select |
| col_o | output | 101 | Column data of the active row |
| pol_o | output | 1 | Frame polarity |

## Verification
A wrong slot counter or accumulator shows up as a slot length that is off by one. This is visible at the first row boundary that follows, and as a frame total other than 3072 by the next wrap. A wrong row counter or bank/bit mapping puts a wrong one-hot code or a wrong column word on the ports in the very cycle the slot starts. A missing latch lets a mid-slot memory or mode change leak onto col_o within one cycle. A polarity or freeze fault shows at the next frame start or on the first cycle after power-down ends.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK   = 2'b00,
    MODE_ALL_ON  = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_INVERSE = 2'b11
  } disp_mode_e;

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter  int unsigned ROWS       = 40,
  parameter  int unsigned FRAME_CLKS = 3072,
  localparam int unsigned ROW_W      = $clog2(ROWS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [ROW_W-1:0] row_o,
  output logic             slot_end_o,
  output logic             pol_o
);

  localparam int unsigned BASE  = FRAME_CLKS / ROWS;
  localparam int unsigned REM   = FRAME_CLKS % ROWS;
  localparam int unsigned CNT_W = $clog2(BASE + 1);
  localparam int unsigned ACC_W = $clog2(ROWS) + 1;

  localparam logic [ACC_W-1:0] REM_V    = ACC_W'(REM);
  localparam logic [ACC_W-1:0] ROWS_V   = ACC_W'(ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic [ROW_W-1:0] row_q;
  logic             pol_q, long_slot, at_last;

  // long slot whenever the fractional remainder overflows one row
  always_comb begin
    acc_sum   = acc_q + REM_V;
    long_slot = (acc_sum >= ROWS_V);
    last_cnt  = long_slot ? CNT_W'(BASE) : CNT_W'(BASE - 1);
    at_last   = (cnt_q == last_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
      row_q <= '0;
      pol_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      acc_q <= '0;
      row_q <= '0;
      pol_q <= 1'b0;
    end else if (en_i) begin
      if (at_last) begin
        cnt_q <= '0;
        acc_q <= long_slot ? (acc_sum - ROWS_V) : acc_sum;
        if (row_q == ROW_LAST) begin
          row_q <= '0;
          pol_q <= ~pol_q;
        end else begin
          row_q <= row_q + 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign row_o      = row_q;
  assign pol_o      = pol_q;
  assign slot_end_o = en_i && at_last;

endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch
  import lcd_scan_pkg::*;
#(
  parameter  int unsigned ROWS    = 40,
  parameter  int unsigned COLS    = 101,
  parameter  int unsigned BANK_W  = 8,
  localparam int unsigned ROW_W   = $clog2(ROWS),
  localparam int unsigned BANKS   = (ROWS + BANK_W - 1) / BANK_W,
  localparam int unsigned BANK_IW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ROW_W-1:0]         fetch_row_i,
  input  disp_mode_e               mode_i,
  output logic [BANK_IW-1:0]       rd_bank_o,
  input  logic [COLS*BANK_W-1:0]   rd_data_i,
  output logic [COLS-1:0]          col_o
);

  localparam int unsigned BIT_W = (BANK_W > 1) ? $clog2(BANK_W) : 1;

  logic [BIT_W-1:0] bit_sel;
  logic [COLS-1:0]  raw_bits, shaped, col_q;

  assign rd_bank_o = BANK_IW'(fetch_row_i / ROW_W'(BANK_W));
  assign bit_sel   = BIT_W'(fetch_row_i % ROW_W'(BANK_W));

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [BANK_W-1:0] byte_w;
    assign byte_w      = rd_data_i[c*BANK_W +: BANK_W];
    assign raw_bits[c] = byte_w[bit_sel];
  end

  always_comb begin
    unique case (mode_i)
      MODE_BLANK:   shaped = '0;
      MODE_ALL_ON:  shaped = '1;
      MODE_NORMAL:  shaped = raw_bits;
      default:      shaped = ~raw_bits;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     col_q <= '0;
    else if (load_i) col_q <= shaped;
  end

  assign col_o = col_q;

endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter  int unsigned ROWS       = 40,
  parameter  int unsigned COLS       = 101,
  parameter  int unsigned BANK_W     = 8,
  parameter  int unsigned FRAME_CLKS = 3072,
  localparam int unsigned BANKS      = (ROWS + BANK_W - 1) / BANK_W,
  localparam int unsigned BANK_IW    = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   pd_i,
  input  logic [1:0]             disp_mode_i,
  output logic [BANK_IW-1:0]     rd_bank_o,
  input  logic [COLS*BANK_W-1:0] rd_data_i,
  output logic [ROWS-1:0]        row_sel_o,
  output logic [COLS-1:0]        col_o,
  output logic                   pol_o
);

  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic             run, slot_end, pol, load, show;
  logic [ROW_W-1:0] row, fetch_row;
  logic [ROWS-1:0]  row_dec;
  logic [COLS-1:0]  col_q;

  lcd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  lcd_slot_timer #(.ROWS(ROWS), .FRAME_CLKS(FRAME_CLKS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (!run),
    .en_i       (run && !pd_i),
    .row_o      (row),
    .slot_end_o (slot_end),
    .pol_o      (pol)
  );

  // while held, keep row 0 primed so it is valid on the first run cycle
  always_comb begin
    if (!run || row == ROW_LAST) fetch_row = '0;
    else                         fetch_row = row + 1'b1;
  end

  assign load = !run || slot_end;

  lcd_row_fetch #(.ROWS(ROWS), .COLS(COLS), .BANK_W(BANK_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .fetch_row_i (fetch_row),
    .mode_i      (disp_mode_e'(disp_mode_i)),
    .rd_bank_o   (rd_bank_o),
    .rd_data_i   (rd_data_i),
    .col_o       (col_q)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_dec[r] = (row == ROW_W'(r));
  end

  assign show      = run && !pd_i;
  assign row_sel_o = show ? row_dec : '0;
  assign col_o     = show ? col_q : '0;
  assign pol_o     = show && pol;

endmodule

// File: rtl/lcd_scan_ctrl_chk.sv
module lcd_scan_ctrl_chk #(
  parameter int unsigned ROWS       = 40,
  parameter int unsigned COLS       = 101,
  parameter int unsigned FRAME_CLKS = 3072
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pd_i,
  input logic [ROWS-1:0] row_sel_o,
  input logic [COLS-1:0] col_o,
  input logic            pol_o
);

  localparam int unsigned BASE  = FRAME_CLKS / ROWS;
  localparam int unsigned CNT_W = $clog2(BASE + 2);

  logic [ROWS-1:0]  last_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      cnt_q  <= '0;
    end else if (!pd_i && row_sel_o != '0) begin
      last_q <= row_sel_o;
      cnt_q  <= (row_sel_o == last_q) ? cnt_q + 1'b1 : '0;
    end
  end

  // R3
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));

  // R3
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && row_sel_o != '0) |=> (pd_i || row_sel_o == $past(row_sel_o) ||
      row_sel_o == {$past(row_sel_o[ROWS-2:0]), $past(row_sel_o[ROWS-1])}));

  // R2
  slot_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BASE));

  // R2
  slot_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && row_sel_o != '0 && last_q != '0 && row_sel_o != last_q) |-> cnt_q >= CNT_W'(BASE - 1));

  // R6
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && row_sel_o != '0) |=> (pd_i || row_sel_o != $past(row_sel_o) || col_o == $past(col_o)));

  // R7
  pol_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && row_sel_o[ROWS-1]) |=> (pd_i || !row_sel_o[0] || pol_o != $past(pol_o)));

  // R7
  pol_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_i && row_sel_o != '0 && !row_sel_o[ROWS-1]) |=> (pd_i || pol_o == $past(pol_o)));

  // R8
  pd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (row_sel_o == '0 && col_o == '0 && !pol_o));

endmodule

bind lcd_scan_ctrl lcd_scan_ctrl_chk #(
  .ROWS(ROWS), .COLS(COLS), .FRAME_CLKS(FRAME_CLKS)
) chk_i (.*);

// File: tb/lcd_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module lcd_scan_ctrl_tb_top;

  localparam int ROWS  = 40;
  localparam int COLS  = 101;
  localparam int BW    = 8;
  localparam int FRAME = 3072;
  localparam int BASE  = FRAME / ROWS;
  localparam int REM   = FRAME % ROWS;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 pd = 1'b0;
  logic [1:0]           mode = 2'b10;
  logic [2:0]           rd_bank;
  logic [COLS*BW-1:0]   rd_data;
  logic [ROWS-1:0]      row_sel;
  logic [COLS-1:0]      col;
  logic                 pol;

  int seed = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int cur_row = -1, dur = 0, frame = 0, frame_sum = 0;
  logic [COLS-1:0] exp_q;

  always #4 clk = ~clk;

  lcd_scan_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pd_i        (pd),
    .disp_mode_i (mode),
    .rd_bank_o   (rd_bank),
    .rd_data_i   (rd_data),
    .row_sel_o   (row_sel),
    .col_o       (col),
    .pol_o       (pol)
  );

  function automatic logic [7:0] pat(int b, int c, int s);
    return 8'((b * 37 + c * 11 + s * 53 + 5) ^ ((c * 3) >> 2));
  endfunction

  always_comb
    for (int c = 0; c < COLS; c++) rd_data[c*BW +: BW] = pat(int'(rd_bank), c, seed);

  function automatic int slot_len(int r);
    return BASE + ((r + 1) * REM / ROWS - r * REM / ROWS);
  endfunction

  // R4 bank r/8, bit r%8; R5 mode encoding
  function automatic logic [COLS-1:0] exp_col(int r, logic [1:0] m, int s);
    logic [COLS-1:0] v;
    logic [7:0] byte_v;
    for (int c = 0; c < COLS; c++) begin
      byte_v = pat(r / 8, c, s);
      case (m)
        2'b00:   v[c] = 1'b0;
        2'b01:   v[c] = 1'b1;
        2'b10:   v[c] = byte_v[r % 8];
        default: v[c] = ~byte_v[r % 8];
      endcase
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sample();
    int idx;
    if (pd) begin
      check(row_sel == '0 && !pol, "R8", {pol, row_sel}, 0);
      check(col == '0, "R8", col, 0);
      return;
    end
    idx = -1;
    for (int i = 0; i < ROWS; i++) if (row_sel[i]) idx = i;
    check($countones(row_sel) == 1, "R3", $countones(row_sel), 1);
    if (idx < 0) return;
    if (idx == cur_row) begin
      dur++;
      check(col == exp_q, "R6", col, exp_q);
      return;
    end
    if (cur_row < 0) begin
      check(idx == 0, "R9", idx, 0);
    end else begin
      // R2 also covers the frozen count across power-down (R8)
      check(dur == slot_len(cur_row), "R2", dur, slot_len(cur_row));
      frame_sum += dur;
      check(idx == (cur_row + 1) % ROWS, "R3", idx, (cur_row + 1) % ROWS);
      if (idx == 0) begin
        check(frame_sum == FRAME, "R1", frame_sum, FRAME);
        frame++;
        frame_sum = 0;
      end
    end
    exp_q = exp_col(idx, mode, seed);
    check(col == exp_q, (mode == 2'b10) ? "R4" : "R5", col, exp_q);
    check(pol == frame[0], "R7", pol, frame[0]);
    cur_row = idx;
    dur = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(row_sel == '0 && col == '0 && !pol, "R9", {pol, row_sel}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(row_sel == '0, "R9", row_sel, 0);
    cur_row = -1; dur = 0; frame = 0; frame_sum = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1: watchdog expired, actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    do_reset();
    for (int t = 0; t < 17000; t++) begin
      @(negedge clk);
      sample();
      case (t)
        1000:  mode = 2'b11;   // R6 mid-slot mode change
        2000:  seed = 1;       // R6 mid-slot data change
        3100:  mode = 2'b01;
        4000:  pd = 1'b1;      // R8
        4060:  pd = 1'b0;
        6500:  mode = 2'b00;
        9500:  mode = 2'b10;
        9600:  seed = 2;
        12400: mode = 2'b11;
        13000: pd = 1'b1;
        13001: pd = 1'b0;
        default: ;
      endcase
    end
    mode = 2'b10;
    do_reset();                // R9 mid-run reset
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      sample();
    end
    done = 1;
    finish_run();
  end

endmodule